// File: doc/BRIEF.md
# Sample Offset Correction and Output Formatter

This stage sits between the converter core and the sample buffer. Each valid sample from the core arrives as a 14-bit straight-binary code, where mid-scale 8192 stands for zero. The stage can subtract a host-programmed offset from it. The result then leaves in either straight binary or two's complement. An out-of-range flag comes in with each sample, passes through the same register and leaves in the same cycle as the data word it belongs to.

The subtraction uses signed arithmetic and clamps at the 14-bit limits. A clamped result also raises the out-of-range flag. The offset word is read in the same format the host is currently reading results in. Control inputs are sampled only when a valid sample is present, so a control change takes effect on the next valid sample.

Top module: `smp_ofs_fmt_top`

## Requirements
- R1: After reset, `outValid`, `outData` and `outOverRange` are all 0.
- R2: `outValid` is high exactly one clock after `inValid` was high, and low one clock after `inValid` was low.
- R3: In a cycle with `inValid` low, `outData` and `outOverRange` keep their previous values on the next clock.
- R4: With `cfgOffsetBypass` = 1 and `cfgTwosComp` = 0, `outData` equals the input sample one clock later.
- R5: With `cfgOffsetBypass` = 1 and `cfgTwosComp` = 1, `outData` equals the input sample with bit 13 inverted.
- R6: With `cfgOffsetBypass` = 0, the signed result is (sample − 8192) − offset. The offset is read as (`cfgOffset` − 8192) when `cfgTwosComp` = 0, and as a signed 14-bit value when `cfgTwosComp` = 1. The result is presented as result + 8192 in straight binary, or as its 14-bit two's-complement value.
- R7: A corrected result above +8191 clamps to +8191, and one below −8192 clamps to −8192. In either case the out-of-range output is set for that sample.
- R8: `outOverRange` is `inOverRange` OR the clamp condition of the same sample, and it appears in the same cycle as that sample's data.
- R9: The control inputs are used only in the clock of a valid sample, so changing them affects only samples that arrive after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample present |
| inSample | input | 14 | Core result, straight binary |
| inOverRange | input | 1 | Out-of-range flag from the core |
| cfgOffsetBypass | input | 1 | 0 = subtract offset, 1 = pass unchanged |
| cfgTwosComp | input | 1 | 0 = straight binary, 1 = two's complement |
| cfgOffset | input | 14 | Offset value, in the selected format |
| outValid | output | 1 | Output sample present |
| outData | output | 14 | Corrected and formatted sample |
| outOverRange | output | 1 | Out-of-range flag aligned with `outData` |

## Verification
Every result is due exactly one clock after the valid sample that produced it. This applies to the data word, the flag and `outValid` alike. The bench drives each input set on a falling edge and compares the outputs on the following falling edge, after the single register has been loaded. On cycles without a valid sample, the bench expects the values from the previous check to stay unchanged. Because the offset, format and bypass inputs are randomised on every cycle, including invalid ones, a control input that is used at the wrong time shows up as a mismatch on the next sample.

// File: rtl/smp_ofs_fmt_pkg.sv
package smp_ofs_fmt_pkg;
  localparam int SAMPLE_W = 14;

  typedef struct packed {
    logic capture;
    logic subEn;
    logic twosOut;
  } dpStrobes_t;
endpackage

// File: rtl/smp_ofs_fmt_ctrl.sv
module smp_ofs_fmt_ctrl
  import smp_ofs_fmt_pkg::*;
(
  input  logic       inValid,
  input  logic       cfgOffsetBypass,
  input  logic       cfgTwosComp,
  output dpStrobes_t strobes
);
  // Control is only meaningful alongside a valid sample (R9).
  always_comb begin
    strobes.capture = inValid;
    strobes.subEn   = inValid & ~cfgOffsetBypass;
    strobes.twosOut = inValid & cfgTwosComp;
  end
endmodule

// File: rtl/smp_ofs_fmt_dp.sv
module smp_ofs_fmt_dp
  import smp_ofs_fmt_pkg::*;
#(
  parameter int W = SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dpStrobes_t   strobes,
  input  logic [W-1:0] inSample,
  input  logic         inOverRange,
  input  logic [W-1:0] cfgOffset,
  output logic         outValid,
  output logic [W-1:0] outData,
  output logic         outOverRange
);
  localparam int EXT_W = W + 1;

  logic [W-1:0]     sampleSigned;
  logic [W-1:0]     offsetSigned;
  logic [EXT_W-1:0] diffExt;
  logic             ovfPos;
  logic             ovfNeg;
  logic [W-1:0]     corrected;
  logic [W-1:0]     formatted;

  always_comb begin
    // straight binary to signed: flip the sign bit
    sampleSigned = {~inSample[W-1], inSample[W-2:0]};
    offsetSigned = strobes.twosOut ? cfgOffset : {~cfgOffset[W-1], cfgOffset[W-2:0]};
    diffExt = {sampleSigned[W-1], sampleSigned} - {offsetSigned[W-1], offsetSigned};
    ovfPos = strobes.subEn & ~diffExt[EXT_W-1] & diffExt[W-1];
    ovfNeg = strobes.subEn & diffExt[EXT_W-1] & ~diffExt[W-1];
    if (!strobes.subEn)   corrected = sampleSigned;
    else if (ovfPos)      corrected = {1'b0, {(W-1){1'b1}}};
    else if (ovfNeg)      corrected = {1'b1, {(W-1){1'b0}}};
    else                  corrected = diffExt[W-1:0];
    formatted = strobes.twosOut ? corrected : {~corrected[W-1], corrected[W-2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid     <= 1'b0;
      outData      <= '0;
      outOverRange <= 1'b0;
    end else begin
      outValid <= strobes.capture;
      if (strobes.capture) begin
        outData      <= formatted;
        outOverRange <= inOverRange | ovfPos | ovfNeg;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.capture |=> outValid); // R2
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.capture |=> !outValid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.capture |=> ($stable(outData) && $stable(outOverRange))); // R3
  AST_BYPASS_BIN: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.capture && !strobes.subEn && !strobes.twosOut) |=> outData == $past(inSample)); // R4
  AST_FLAG_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.capture && inOverRange) |=> outOverRange); // R8
  AST_BYPASS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.capture && !strobes.subEn) |=> outOverRange == $past(inOverRange)); // R8
endmodule

// File: rtl/smp_ofs_fmt_top.sv
module smp_ofs_fmt_top
  import smp_ofs_fmt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic                inOverRange,
  input  logic                cfgOffsetBypass,
  input  logic                cfgTwosComp,
  input  logic [SAMPLE_W-1:0] cfgOffset,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outData,
  output logic                outOverRange
);
  dpStrobes_t strobes;

  smp_ofs_fmt_ctrl ctrl_i (
    .inValid        (inValid),
    .cfgOffsetBypass(cfgOffsetBypass),
    .cfgTwosComp    (cfgTwosComp),
    .strobes        (strobes)
  );

  smp_ofs_fmt_dp #(.W(SAMPLE_W)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .inSample    (inSample),
    .inOverRange (inOverRange),
    .cfgOffset   (cfgOffset),
    .outValid    (outValid),
    .outData     (outData),
    .outOverRange(outOverRange)
  );
endmodule

// File: tb/smp_ofs_fmt_tb.sv
module smp_ofs_fmt_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [13:0] inSample = '0;
  logic        inOverRange = 1'b0;
  logic        cfgOffsetBypass = 1'b1;
  logic        cfgTwosComp = 1'b0;
  logic [13:0] cfgOffset = '0;
  logic        outValid;
  logic [13:0] outData;
  logic        outOverRange;

  int checks = 0;
  int errors = 0;
  logic [13:0] expData = '0;
  logic        expOor = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smp_ofs_fmt_top dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSample(inSample),
    .inOverRange(inOverRange), .cfgOffsetBypass(cfgOffsetBypass),
    .cfgTwosComp(cfgTwosComp), .cfgOffset(cfgOffset),
    .outValid(outValid), .outData(outData), .outOverRange(outOverRange)
  );

  // Expected {flag, data} from the requirement text.
  function automatic logic [14:0] model(input logic [13:0] s, input logic oor,
                                        input logic byp, input logic twos,
                                        input logic [13:0] ofs);
    int r, off;
    logic sat;
    r = int'(s) - 8192;
    sat = 1'b0;
    if (!byp) begin
      if (twos) off = (int'(ofs) >= 8192) ? int'(ofs) - 16384 : int'(ofs);
      else      off = int'(ofs) - 8192;
      r = r - off;
      if (r > 8191)  begin r = 8191;  sat = 1'b1; end
      if (r < -8192) begin r = -8192; sat = 1'b1; end
    end
    if (twos) r = r & 16383;
    else      r = r + 8192;
    return {oor | sat, r[13:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at falling edge, result is due one posedge later: sample at next falling edge.
  task automatic step(input logic v, input logic [13:0] s, input logic oor,
                      input logic byp, input logic twos, input logic [13:0] ofs,
                      input string req);
    logic [14:0] m;
    inValid = v; inSample = s; inOverRange = oor;
    cfgOffsetBypass = byp; cfgTwosComp = twos; cfgOffset = ofs;
    if (v) begin
      m = model(s, oor, byp, twos, ofs);
      expData = m[13:0];
      expOor = m[14];
    end
    @(negedge clk);
    check({req, " valid"}, 32'(outValid), 32'(v));
    check({req, " data"}, 32'(outData), 32'(expData));
    check({req, " flag"}, 32'(outOverRange), 32'(expOor));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", 32'(outValid), 0);
    check("R1 data", 32'(outData), 0);
    check("R1 flag", 32'(outOverRange), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 bypass straight binary
    step(1, 14'h1234, 0, 1, 0, 14'h0777, "R4");
    // R5 bypass two's complement: MSB inverted
    step(1, 14'h0005, 0, 1, 1, 14'h0777, "R5");
    // R3 idle hold with changed inputs
    step(0, 14'h3FFF, 1, 0, 0, 14'h0000, "R3");
    // R6 straight binary offset 8200 -> subtract 8
    step(1, 14'd8192, 0, 0, 0, 14'd8200, "R6");
    // R6 two's complement offset -3
    step(1, 14'd8192, 0, 0, 1, 14'h3FFD, "R6");
    // R7 positive clamp
    step(1, 14'h3FFF, 0, 0, 0, 14'h0000, "R7");
    // R7 negative clamp
    step(1, 14'h0000, 0, 0, 0, 14'h3FFF, "R7");
    // R8 flag passed with data, no clamp
    step(1, 14'd9000, 1, 0, 0, 14'd8192, "R8");
    // R2 back-to-back then idle
    step(1, 14'd100, 0, 1, 0, 14'd0, "R2");
    step(0, 14'd200, 0, 1, 1, 14'd0, "R2");
    // R9 random stimulus, control changes on every cycle
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 10) < 7, 14'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 14'($urandom), "R9");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule